// File: doc/BRIEF.md
# Text RAM Write Guard and Glyph Window

This block sits between a CPU data port and the memories behind the text screen. A CPU access is given as a byte offset into a 20 KB space. The low 16 KB hold the text cells. The next 4 KB form a small window onto a glyph RAM. Each access is split into byte lanes. A byte access uses lane 0 only. A word access also uses lane 1, which covers the byte at offset+1. Each lane is checked against its own area rules, and the block drives the text RAM and glyph RAM write and read ports for that lane. It sends back read data, reports which display cells were changed, and keeps two sticky flags.

The text space has three parts. The lowest 8 KB takes every byte. The area above it, up to 32 bytes from the top, keeps only even bytes. The top 32 bytes also keep only even bytes, and one of every two words there is also locked until a protection input is raised. In the glyph window, an odd offset writes to the glyph RAM at a high base pointer plus a 4-bit index taken from the offset. A read uses the high base for odd offsets and the low base for even offsets. Both base pointers and the window-enable input come from host logic that is not part of this block.

Top module: `tgw_top`

## Requirements
- R1: Offsets 0x0000 to 0x1FFF accept a write at every byte offset, odd or even, and a later read returns the byte written.
- R2: Offsets 0x2000 to 0x3FDF store writes at even offsets only. A write to an odd offset there changes no memory, marks no cell and leaves `text_changed` unchanged.
- R3: Offsets 0x3FE0 to 0x3FFF drop odd offsets. An even offset with bit 1 clear is stored. An even offset with bit 1 set is stored only while `prot_en` is 1.
- R4: In the window at 0x4000 to 0x4FFF, a write lane with offset bit 0 set and `glyph_wr_en` at 1 writes glyph RAM address `glyph_hi_base + offset[4:1]`, modulo 256. A write at an even offset, or any write while `glyph_wr_en` is 0, is dropped.
- R5: `glyph_written` rises in the cycle after the first accepted glyph write and stays at 1 until reset.
- R6: A read lane in the window uses glyph RAM address `base + offset[4:1]`, modulo 256. The base is `glyph_hi_base` for an odd offset and `glyph_lo_base` for an even offset.
- R7: In the cycle after a text byte is accepted on lane k, `dirty_vld[k]` is 1 and `dirty_idx[k]` equals (offset >> 1) mod 4096. `text_changed` goes to 1 at the same time and stays at 1.
- R8: In a word access, lane 0 carries the low data byte at the given offset and lane 1 carries the high byte at offset+1. A word write at 0x1FFF stores both bytes and marks cells 0xFFF (lane 0) and 0x000 (lane 1).
- R9: A word write to an odd offset in the 0x2000 to 0x3FDF area stores only the high data byte, at the next even offset. Only lane 1 is marked dirty.
- R10: A read gives `rsp_valid` for one cycle in the following cycle. `rsp_data[7:0]` holds lane 0 and `rsp_data[15:8]` holds lane 1, or 0 for a byte read. A read never writes memory and never marks a cell dirty.
- R11: Offsets from 0x5000 upward drop writes and read as 0xFF.
- R12: After reset, `rsp_valid`, `dirty_vld`, `text_changed` and `glyph_written` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = two-byte access (lanes 0 and 1) |
| req_addr | input | 15 | Byte offset of lane 0 |
| req_wdata | input | 16 | Write data; low byte goes to lane 0 |
| prot_en | input | 1 | Unlocks the protected words in the top 32 bytes |
| glyph_wr_en | input | 1 | Allows writes through the glyph window |
| glyph_hi_base | input | 8 | Glyph base pointer for odd offsets |
| glyph_lo_base | input | 8 | Glyph base pointer for even offsets (reads only) |
| txt_we | output | 2 | Text RAM byte write strobe per lane |
| txt_addr | output | 2x14 | Text RAM byte address per lane |
| txt_wdata | output | 2x8 | Text RAM write byte per lane |
| txt_rdata | input | 2x8 | Text RAM read byte per lane (same-cycle read) |
| gly_we | output | 2 | Glyph RAM write strobe per lane |
| gly_addr | output | 2x8 | Glyph RAM address per lane |
| gly_wdata | output | 2x8 | Glyph RAM write byte per lane |
| gly_rdata | input | 2x8 | Glyph RAM read byte per lane (same-cycle read) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 16 | Read data |
| dirty_vld | output | 2 | Cell marked by lane k in the previous cycle |
| dirty_idx | output | 2x12 | Index of the marked cell per lane |
| text_changed | output | 1 | Sticky: some text byte was stored |
| glyph_written | output | 1 | Sticky: some glyph byte was stored |

## Verification
The assertions assume that both RAMs return read data in the same cycle for the address the block drives. They also assume that `prot_en`, `glyph_wr_en` and both base pointers stay steady while an access is being presented. The stimulus changes those controls only in idle cycles, after the last access that used the old values has been clocked. It models both RAMs in the same-cycle way. Accesses are single-cycle pulses with a defined offset, so each response and each dirty report belongs to exactly one request.

// File: rtl/tgw_pkg.sv
package tgw_pkg;

    // Where a single byte lane of an access lands
    typedef enum logic [1:0] {
        LANE_NONE  = 2'd0,
        LANE_TEXT  = 2'd1,
        LANE_GLYPH = 2'd2
    } lane_kind_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/tgw_lane.sv
module tgw_lane
    import tgw_pkg::*;
#(
    parameter int unsigned LANE_AW    = 16,
    parameter int unsigned TXT_BYTES  = 16384,
    parameter int unsigned CODE_BYTES = 8192,
    parameter int unsigned TOP_BYTES  = 32,
    parameter int unsigned WIN_BYTES  = 4096,
    parameter int unsigned GLY_AW     = 8,
    parameter int unsigned IDX_BITS   = 4,
    parameter int unsigned TXT_AW     = $clog2(TXT_BYTES),
    parameter int unsigned CELL_AW    = 12
) (
    input  logic               lane_en,
    input  logic               is_write,
    input  logic [LANE_AW-1:0] addr,
    input  logic               prot_en,
    input  logic               gwin_en,
    input  logic [GLY_AW-1:0]  hi_base,
    input  logic [GLY_AW-1:0]  lo_base,
    output lane_kind_e         kind,
    output logic               txt_we,
    output logic [TXT_AW-1:0]  txt_addr,
    output logic               gly_we,
    output logic [GLY_AW-1:0]  gly_addr,
    output logic [CELL_AW-1:0] cell_idx
);

    localparam int unsigned TOP_START = TXT_BYTES - TOP_BYTES;
    localparam int unsigned WIN_END   = TXT_BYTES + WIN_BYTES;

    logic                in_text;
    logic                in_win;
    logic                in_code;
    logic                in_top;
    logic                text_ok;
    logic [IDX_BITS-1:0] win_idx;

    always_comb begin
        in_text = addr < LANE_AW'(TXT_BYTES);
        in_win  = !in_text && (addr < LANE_AW'(WIN_END));
        in_code = addr < LANE_AW'(CODE_BYTES);
        in_top  = in_text && (addr >= LANE_AW'(TOP_START));
        win_idx = addr[IDX_BITS:1];

        if (in_code) begin
            text_ok = 1'b1;
        end else if (!in_top) begin
            text_ok = !addr[0];
        end else begin
            text_ok = !addr[0] && (!addr[1] || prot_en);
        end

        if (in_text) begin
            kind = LANE_TEXT;
        end else if (in_win) begin
            kind = LANE_GLYPH;
        end else begin
            kind = LANE_NONE;
        end

        txt_we   = lane_en && is_write && in_text && text_ok;
        gly_we   = lane_en && is_write && in_win && addr[0] && gwin_en;
        txt_addr = addr[TXT_AW-1:0];
        gly_addr = (addr[0] ? hi_base : lo_base) + GLY_AW'(win_idx);
        cell_idx = addr[CELL_AW:1];
    end

endmodule

// File: rtl/tgw_flags.sv
module tgw_flags
    import tgw_pkg::*;
#(
    parameter int unsigned CELL_AW = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              mark_vld,
    input  logic [LANES-1:0][CELL_AW-1:0] mark_idx,
    input  logic                          glyph_hit,
    output logic [LANES-1:0]              dirty_vld,
    output logic [LANES-1:0][CELL_AW-1:0] dirty_idx,
    output logic                          text_changed,
    output logic                          glyph_written
);

    typedef struct packed {
        logic [LANES-1:0]              vld;
        logic [LANES-1:0][CELL_AW-1:0] idx;
        logic                          changed;
        logic                          glyph;
    } flag_st_t;

    flag_st_t st_d;
    flag_st_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.vld     = mark_vld;
        st_d.changed = st_q.changed | (|mark_vld);
        st_d.glyph   = st_q.glyph | glyph_hit;
        for (int k = 0; k < LANES; k++) begin
            if (mark_vld[k]) begin
                st_d.idx[k] = mark_idx[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dirty_vld     = st_q.vld;
    assign dirty_idx     = st_q.idx;
    assign text_changed  = st_q.changed;
    assign glyph_written = st_q.glyph;

endmodule

// File: rtl/tgw_top.sv
module tgw_top
    import tgw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 15,
    parameter int unsigned TXT_BYTES  = 16384,
    parameter int unsigned CODE_BYTES = 8192,
    parameter int unsigned TOP_BYTES  = 32,
    parameter int unsigned WIN_BYTES  = 4096,
    parameter int unsigned CELL_COUNT = 4096,
    parameter int unsigned GLY_AW     = 8,
    parameter int unsigned IDX_BITS   = 4,
    parameter int unsigned TXT_AW     = $clog2(TXT_BYTES),
    parameter int unsigned CELL_AW    = $clog2(CELL_COUNT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_word,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [15:0]                  req_wdata,
    input  logic                         prot_en,
    input  logic                         glyph_wr_en,
    input  logic [GLY_AW-1:0]            glyph_hi_base,
    input  logic [GLY_AW-1:0]            glyph_lo_base,
    output logic [1:0]                   txt_we,
    output logic [1:0][TXT_AW-1:0]       txt_addr,
    output logic [1:0][7:0]              txt_wdata,
    input  logic [1:0][7:0]              txt_rdata,
    output logic [1:0]                   gly_we,
    output logic [1:0][GLY_AW-1:0]       gly_addr,
    output logic [1:0][7:0]              gly_wdata,
    input  logic [1:0][7:0]              gly_rdata,
    output logic                         rsp_valid,
    output logic [15:0]                  rsp_data,
    output logic [1:0]                   dirty_vld,
    output logic [1:0][CELL_AW-1:0]      dirty_idx,
    output logic                         text_changed,
    output logic                         glyph_written
);

    localparam int unsigned LANE_AW   = ADDR_W + 1;
    localparam int unsigned TOP_START = TXT_BYTES - TOP_BYTES;

    typedef struct packed {
        logic        vld;
        logic [15:0] data;
    } rsp_st_t;

    logic [LANES-1:0][LANE_AW-1:0] lane_addr;
    logic [LANES-1:0]              lane_en;
    lane_kind_e                    lane_kind [LANES];
    logic [LANES-1:0][CELL_AW-1:0] lane_cell;
    logic [LANES-1:0][7:0]         lane_byte;
    rsp_st_t                       rsp_d;
    rsp_st_t                       rsp_q;

    assign lane_addr[0] = LANE_AW'(req_addr);
    assign lane_addr[1] = LANE_AW'(req_addr) + LANE_AW'(1);
    assign lane_en[0]   = req_valid;
    assign lane_en[1]   = req_valid && req_word;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tgw_lane #(
            .LANE_AW    (LANE_AW),
            .TXT_BYTES  (TXT_BYTES),
            .CODE_BYTES (CODE_BYTES),
            .TOP_BYTES  (TOP_BYTES),
            .WIN_BYTES  (WIN_BYTES),
            .GLY_AW     (GLY_AW),
            .IDX_BITS   (IDX_BITS),
            .TXT_AW     (TXT_AW),
            .CELL_AW    (CELL_AW)
        ) u_lane (
            .lane_en  (lane_en[k]),
            .is_write (req_write),
            .addr     (lane_addr[k]),
            .prot_en  (prot_en),
            .gwin_en  (glyph_wr_en),
            .hi_base  (glyph_hi_base),
            .lo_base  (glyph_lo_base),
            .kind     (lane_kind[k]),
            .txt_we   (txt_we[k]),
            .txt_addr (txt_addr[k]),
            .gly_we   (gly_we[k]),
            .gly_addr (gly_addr[k]),
            .cell_idx (lane_cell[k])
        );

        assign txt_wdata[k] = req_wdata[8*k +: 8];
        assign gly_wdata[k] = req_wdata[8*k +: 8];

        always_comb begin
            case (lane_kind[k])
                LANE_TEXT:  lane_byte[k] = txt_rdata[k];
                LANE_GLYPH: lane_byte[k] = gly_rdata[k];
                default:    lane_byte[k] = 8'hFF;
            endcase
        end

        // Above the code area only even bytes may be stored
        assert_attr_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (txt_we[k] && (txt_addr[k] >= TXT_AW'(CODE_BYTES))) |-> !txt_addr[k][0]);

        // Locked words in the top area need the protection input
        assert_prot_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (txt_we[k] && (txt_addr[k] >= TXT_AW'(TOP_START)) && txt_addr[k][1]) |-> prot_en);
    end

    tgw_flags #(
        .CELL_AW (CELL_AW)
    ) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .mark_vld      (txt_we),
        .mark_idx      (lane_cell),
        .glyph_hit     (|gly_we),
        .dirty_vld     (dirty_vld),
        .dirty_idx     (dirty_idx),
        .text_changed  (text_changed),
        .glyph_written (glyph_written)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid && !req_write;
        if (rsp_d.vld) begin
            rsp_d.data = {(req_word ? lane_byte[1] : 8'h00), lane_byte[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_data  = rsp_q.data;

    assert_glyph_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|gly_we) |-> (glyph_wr_en && req_write && $onehot0(gly_we)));

    assert_glyph_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gly_we) |=> glyph_written);

    assert_dirty_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|txt_we) |=> (dirty_vld == $past(txt_we)));

    assert_changed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dirty_vld) |-> text_changed);

    assert_byte_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_word |-> (!txt_we[1] && !gly_we[1]));

    assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> ((txt_we == 2'b00) && (gly_we == 2'b00)));

    assert_read_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: tb/tb_tgw_top.sv
`timescale 1ns/1ps
module tb_tgw_top;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_word = 1'b0;
    logic [14:0]      req_addr = '0;
    logic [15:0]      req_wdata = '0;
    logic             prot_en = 1'b0;
    logic             glyph_wr_en = 1'b0;
    logic [7:0]       glyph_hi_base = 8'h40;
    logic [7:0]       glyph_lo_base = 8'h80;
    logic [1:0]       txt_we;
    logic [1:0][13:0] txt_addr;
    logic [1:0][7:0]  txt_wdata;
    logic [1:0][7:0]  txt_rdata = '0;
    logic [1:0]       gly_we;
    logic [1:0][7:0]  gly_addr;
    logic [1:0][7:0]  gly_wdata;
    logic [1:0][7:0]  gly_rdata = '0;
    logic             rsp_valid;
    logic [15:0]      rsp_data;
    logic [1:0]       dirty_vld;
    logic [1:0][11:0] dirty_idx;
    logic             text_changed;
    logic             glyph_written;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tgw_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_word      (req_word),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .prot_en       (prot_en),
        .glyph_wr_en   (glyph_wr_en),
        .glyph_hi_base (glyph_hi_base),
        .glyph_lo_base (glyph_lo_base),
        .txt_we        (txt_we),
        .txt_addr      (txt_addr),
        .txt_wdata     (txt_wdata),
        .txt_rdata     (txt_rdata),
        .gly_we        (gly_we),
        .gly_addr      (gly_addr),
        .gly_wdata     (gly_wdata),
        .gly_rdata     (gly_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .dirty_vld     (dirty_vld),
        .dirty_idx     (dirty_idx),
        .text_changed  (text_changed),
        .glyph_written (glyph_written)
    );

    // Memory models: same-cycle read, write at the clock edge
    logic [7:0] tmem [int];
    logic [7:0] gmem [0:255];

    function automatic logic [7:0] tread(input logic [13:0] a);
        if (tmem.exists(int'(a))) return tmem[int'(a)];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (txt_we[k]) tmem[int'(txt_addr[k])] = txt_wdata[k];
            if (gly_we[k]) gmem[gly_addr[k]] = gly_wdata[k];
        end
    end

    // Scoreboard queues
    bit          q_rd  [$];
    logic [15:0] q_dat [$];
    logic [1:0]  q_dv  [$];
    logic [11:0] q_i0  [$];
    logic [11:0] q_i1  [$];
    string       q_tag [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per observed result
    always @(negedge clk) begin
        if (rst_n && (rsp_valid || (|dirty_vld))) begin
            if (q_rd.size() == 0) begin
                chk(1'b0, "R10 unexpected output", {15'd0, rsp_valid, rsp_data}, 32'd0);
            end else begin
                automatic bit          rd  = q_rd.pop_front();
                automatic logic [15:0] dat = q_dat.pop_front();
                automatic logic [1:0]  dv  = q_dv.pop_front();
                automatic logic [11:0] i0  = q_i0.pop_front();
                automatic logic [11:0] i1  = q_i1.pop_front();
                automatic string       tg  = q_tag.pop_front();
                if (rd) begin
                    chk(rsp_valid && (dirty_vld == 2'b00) && (rsp_data == dat), tg,
                        {13'd0, rsp_valid, dirty_vld, rsp_data}, {13'd0, 1'b1, 2'b00, dat});
                end else begin
                    automatic logic [11:0] e0 = dv[0] ? i0 : dirty_idx[0];
                    automatic logic [11:0] e1 = dv[1] ? i1 : dirty_idx[1];
                    chk(!rsp_valid && (dirty_vld == dv) && (dirty_idx[0] == e0) && (dirty_idx[1] == e1), tg,
                        {5'd0, rsp_valid, dirty_vld, dirty_idx[1], dirty_idx[0]},
                        {5'd0, 1'b0, dv, e1, e0});
                end
            end
        end
    end

    task automatic issue(input bit wr, input bit word, input logic [14:0] a, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_word  = word;
        req_addr  = a;
        req_wdata = wd;
        #1;
        for (int k = 0; k < 2; k++) begin
            txt_rdata[k] = tread(txt_addr[k]);
            gly_rdata[k] = gmem[gly_addr[k]];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
            req_word  = 1'b0;
        end
    endtask

    task automatic wr(input bit word, input logic [14:0] a, input logic [15:0] d,
                      input logic [1:0] dv, input logic [11:0] i0, input logic [11:0] i1, input string tag);
        if (dv != 2'b00) begin
            q_rd.push_back(1'b0); q_dat.push_back(16'h0); q_dv.push_back(dv);
            q_i0.push_back(i0); q_i1.push_back(i1); q_tag.push_back(tag);
        end
        issue(1'b1, word, a, d);
    endtask

    task automatic rd(input bit word, input logic [14:0] a, input logic [15:0] exp, input string tag);
        q_rd.push_back(1'b1); q_dat.push_back(exp); q_dv.push_back(2'b00);
        q_i0.push_back(12'h0); q_i1.push_back(12'h0); q_tag.push_back(tag);
        issue(1'b0, word, a, 16'h0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) gmem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(rsp_valid == 1'b0, "R12 rsp_valid", {31'd0, rsp_valid}, 0);
        chk(dirty_vld == 2'b00, "R12 dirty_vld", {30'd0, dirty_vld}, 0);
        chk(text_changed == 1'b0, "R12 text_changed", {31'd0, text_changed}, 0);
        chk(glyph_written == 1'b0, "R12 glyph_written", {31'd0, glyph_written}, 0);

        // Dropped writes: odd attribute byte, disabled glyph window, out of range
        wr(1'b0, 15'h2001, 16'h0077, 2'b00, 0, 0, "R2");
        wr(1'b0, 15'h4003, 16'h009C, 2'b00, 0, 0, "R4");
        wr(1'b0, 15'h5010, 16'h0066, 2'b00, 0, 0, "R11");
        idle(2);
        chk(text_changed == 1'b0, "R2 odd write left text_changed", {31'd0, text_changed}, 0);
        chk(glyph_written == 1'b0, "R4 disabled window write flag", {31'd0, glyph_written}, 0);
        rd(1'b0, 15'h2001, 16'h0000, "R2 odd attribute byte unchanged");
        rd(1'b0, 15'h4003, 16'h001B, "R4 disabled glyph write ignored");
        rd(1'b0, 15'h5010, 16'h00FF, "R11 out of range reads 0xFF");

        // Code area: every byte
        wr(1'b0, 15'h0011, 16'h005A, 2'b01, 12'h008, 0, "R1 R7 odd code byte");
        wr(1'b0, 15'h0000, 16'h0001, 2'b01, 12'h000, 0, "R1 R7 code byte 0");
        idle(2);
        chk(text_changed == 1'b1, "R7 text_changed set", {31'd0, text_changed}, 1);
        rd(1'b0, 15'h0011, 16'h005A, "R1 readback odd");
        rd(1'b1, 15'h0010, 16'h5A00, "R10 word read text");

        // Attribute area even byte
        wr(1'b0, 15'h2002, 16'h0033, 2'b01, 12'h001, 0, "R2 R7 even attribute byte");
        rd(1'b0, 15'h2002, 16'h0033, "R2 readback even");

        // Protected top area
        idle(1);
        prot_en = 1'b0;
        wr(1'b0, 15'h3FE2, 16'h0044, 2'b00, 0, 0, "R3");
        wr(1'b0, 15'h3FE0, 16'h0055, 2'b01, 12'hFF0, 0, "R3 unlocked word");
        wr(1'b0, 15'h3FE3, 16'h0099, 2'b00, 0, 0, "R3");
        rd(1'b0, 15'h3FE2, 16'h0000, "R3 locked word dropped");
        rd(1'b0, 15'h3FE0, 16'h0055, "R3 bit1 clear stored");
        idle(1);
        prot_en = 1'b1;
        wr(1'b0, 15'h3FE2, 16'h0044, 2'b01, 12'hFF1, 0, "R3 locked word with prot_en");
        wr(1'b0, 15'h3FE3, 16'h0099, 2'b00, 0, 0, "R3");
        rd(1'b1, 15'h3FE2, 16'h0044, "R3 odd top byte dropped");

        // Glyph window
        idle(1);
        glyph_wr_en = 1'b1;
        wr(1'b0, 15'h4003, 16'h009C, 2'b00, 0, 0, "R4");
        wr(1'b0, 15'h4002, 16'h0011, 2'b00, 0, 0, "R4");
        idle(1);
        glyph_wr_en = 1'b0;
        idle(1);
        chk(glyph_written == 1'b1, "R5 glyph_written set", {31'd0, glyph_written}, 1);
        rd(1'b0, 15'h4003, 16'h009C, "R4 odd write stored, even dropped");
        rd(1'b0, 15'h4002, 16'h00DB, "R6 even read uses low base");
        rd(1'b0, 15'h4021, 16'h001A, "R6 index wraps to 0");
        idle(3);
        chk(glyph_written == 1'b1, "R5 glyph_written sticky", {31'd0, glyph_written}, 1);

        // Word corner cases
        wr(1'b1, 15'h1FFF, 16'hBEEF, 2'b11, 12'hFFF, 12'h000, "R8 word at end of code area");
        rd(1'b1, 15'h1FFF, 16'hBEEF, "R8 word readback");
        wr(1'b1, 15'h2005, 16'h1234, 2'b10, 0, 12'h003, "R9 odd attribute word");
        rd(1'b1, 15'h2005, 16'h1200, "R9 only high byte stored");
        rd(1'b1, 15'h4FFF, 16'hFF15, "R11 R6 word at window end");

        idle(4);
        chk(q_rd.size() == 0, "R10 all expected results seen", q_rd.size(), 0);
        chk(text_changed == 1'b1, "R7 text_changed sticky", {31'd0, text_changed}, 1);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule